// File: doc/BRIEF.md
# Four-Bit Shared-Adder Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for 4-bit two's-complement operands `x_i` and `y_i`. A 3-bit opcode selects one of eight operations. Five are arithmetic: add, subtract in either order, increment and decrement. The other three are bitwise AND, OR and XOR. The block drives a result, a signed overflow flag and an unsigned carry flag.

All five arithmetic operations run through a single ripple adder. In front of the adder sit an operand swap multiplexer, a constant-operand multiplexer that supplies all-zeros or all-ones, and a controlled bitwise inverter. A generated carry-in completes the path. An opcode decoder feeds the control logic that produces these selects. The bitwise unit runs in parallel with the adder, and an output multiplexer picks between the two paths. The block has no state, so its outputs follow its inputs with no cycle of delay.

Top module: `alu4_top`

## Requirements
- R1: Opcode 000 gives `res_o = x_i + y_i` modulo 16.
- R2: Opcode 001 gives `res_o = x_i - y_i` modulo 16. The adder forms it as x plus the bitwise inverse of y, with a carry-in of 1.
- R3: Opcode 010 gives `res_o = y_i - x_i` modulo 16. X goes through the inverter, Y goes to the other adder input, and the carry-in is 1.
- R4: Opcode 011 gives `x_i + 1`, formed as x plus 0000 with a carry-in of 1. Opcode 100 gives `x_i - 1`, formed as x plus 1111 with a carry-in of 0. Both results are modulo 16.
- R5: Opcodes 101, 110 and 111 give bitwise `x_i & y_i`, `x_i | y_i` and `x_i ^ y_i`. Result bit i depends only on bit i of each operand.
- R6: For opcodes 000 to 100, `ovf_o` is 1 exactly when the signed value of the result lies outside -8..+7. Examples: 5+4 gives 1001 with `ovf_o` at 1, and -7-2 gives 0111 with `ovf_o` at 1. The flag equals the carry out of bit 3 XOR the carry into bit 3.
- R7: For opcodes 101, 110 and 111, both `ovf_o` and `carry_o` are 0.
- R8: For opcodes 000 to 100, `carry_o` is the adder's carry out of bit 3. This is 1 when:
  - 000: x+y ≥ 16
  - 001: x ≥ y, unsigned
  - 010: y ≥ x, unsigned
  - 011: x = 1111
  - 100: x ≠ 0000
- R9: All outputs depend combinationally on the present inputs. When the operands are 0 and the opcode is 000, the outputs are 0000, 0 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 4 | First operand, two's complement |
| y_i | input | 4 | Second operand, two's complement |
| op_i | input | 3 | Operation select |
| res_o | output | 4 | Operation result |
| ovf_o | output | 1 | Signed overflow |
| carry_o | output | 1 | Adder carry out of the most significant bit |

## Verification
The block holds no state, so a wrong control value shows on the ports in the same cycle it is applied. Such faults include a stuck carry-in, a swapped operand select, a missing inversion, or a wrong constant on the increment and decrement paths. The fault appears only for the opcodes that use the faulty path. A wrong carry-in shifts the result by exactly one. A wrong mux select shows up for any operand pair in which X and Y differ. A missing overflow gate on the logic path shows as a nonzero `ovf_o` or `carry_o` on a bitwise opcode. The bench covers every opcode with all 256 operand pairs, so each of these faults is exposed within a few hundred cycles of its opcode first being applied.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB_XY = 3'd1,
    OP_SUB_YX = 3'd2,
    OP_INC    = 3'd3,
    OP_DEC    = 3'd4,
    OP_AND    = 3'd5,
    OP_OR     = 3'd6,
    OP_XOR    = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    BSEL_Y    = 2'd0,
    BSEL_X    = 2'd1,
    BSEL_ZERO = 2'd2,
    BSEL_ONES = 2'd3
  } bsel_e;

  typedef enum logic [1:0] {
    LSEL_AND = 2'd0,
    LSEL_OR  = 2'd1,
    LSEL_XOR = 2'd2
  } lsel_e;

  typedef struct packed {
    logic  a_is_y;
    bsel_e b_sel;
    logic  inv;
    logic  cin;
    logic  is_logic;
    lsel_e l_sel;
  } alu_ctrl_t;
endpackage

// File: rtl/alu4_ctrl.sv
`timescale 1ns/1ps
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  localparam int NDEC = 8;
  logic [NDEC-1:0] dec;

  assign dec = NDEC'(1) << op_i;

  always_comb begin
    ctrl_o.a_is_y   = dec[OP_SUB_YX];
    ctrl_o.inv      = dec[OP_SUB_XY] | dec[OP_SUB_YX];
    ctrl_o.cin      = dec[OP_SUB_XY] | dec[OP_SUB_YX] | dec[OP_INC];
    ctrl_o.is_logic = dec[OP_AND] | dec[OP_OR] | dec[OP_XOR];
    if (dec[OP_SUB_YX])   ctrl_o.b_sel = BSEL_X;
    else if (dec[OP_INC]) ctrl_o.b_sel = BSEL_ZERO;
    else if (dec[OP_DEC]) ctrl_o.b_sel = BSEL_ONES;
    else                  ctrl_o.b_sel = BSEL_Y;
    if (dec[OP_AND])      ctrl_o.l_sel = LSEL_AND;
    else if (dec[OP_OR])  ctrl_o.l_sel = LSEL_OR;
    else                  ctrl_o.l_sel = LSEL_XOR;
  end

  always_comb begin
    // R2
    if (ctrl_o.inv) inv_needs_cin_chk: assert (ctrl_o.cin);
    // R4
    if (ctrl_o.b_sel == BSEL_ONES) dec_no_cin_chk: assert (!ctrl_o.cin && !ctrl_o.inv);
  end
endmodule

// File: rtl/alu4_arith.sv
`timescale 1ns/1ps
module alu4_arith
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  alu_ctrl_t    ctrl_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         c_pre_o
);
  logic [W-1:0] a_op, b_mux, b_op;
  logic [W:0]   c;

  assign a_op = ctrl_i.a_is_y ? y_i : x_i;

  always_comb begin
    unique case (ctrl_i.b_sel)
      BSEL_Y:    b_mux = y_i;
      BSEL_X:    b_mux = x_i;
      BSEL_ZERO: b_mux = '0;
      default:   b_mux = '1;
    endcase
  end

  assign b_op = b_mux ^ {W{ctrl_i.inv}};
  assign c[0] = ctrl_i.cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_op[i] ^ b_op[i] ^ c[i];
    assign c[i+1]   = (a_op[i] & b_op[i]) | (c[i] & (a_op[i] ^ b_op[i]));
  end

  assign c_msb_o = c[W];
  assign c_pre_o = c[W-1];
endmodule

// File: rtl/alu4_logic.sv
`timescale 1ns/1ps
module alu4_logic
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  lsel_e        sel_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LSEL_AND: res_o[i] = x_i[i] & y_i[i];
        LSEL_OR:  res_o[i] = x_i[i] | y_i[i];
        default:  res_o[i] = x_i[i] ^ y_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alu4_top.sv
`timescale 1ns/1ps
module alu4_top
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o,
  output logic         carry_o
);
  alu_ctrl_t    ctrl;
  logic [W-1:0] sum, lres;
  logic         c_msb, c_pre;

  alu4_ctrl u_ctrl (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  alu4_arith #(.W(W)) u_arith (
    .x_i     (x_i),
    .y_i     (y_i),
    .ctrl_i  (ctrl),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .c_pre_o (c_pre)
  );

  alu4_logic #(.W(W)) u_logic (
    .x_i   (x_i),
    .y_i   (y_i),
    .sel_i (ctrl.l_sel),
    .res_o (lres)
  );

  assign res_o   = ctrl.is_logic ? lres : sum;
  assign ovf_o   = ~ctrl.is_logic & (c_msb ^ c_pre);
  assign carry_o = ~ctrl.is_logic & c_msb;

  always_comb begin
    // R7
    if (op_i >= OP_AND) no_flags_logic_chk: assert (!ovf_o && !carry_o);
    // R6
    if (op_i == OP_ADD) add_ovf_chk: assert (ovf_o == ((x_i[W-1] == y_i[W-1]) && (res_o[W-1] != x_i[W-1])));
    // R5
    if (op_i == OP_XOR) xor_bits_chk: assert (res_o == ((x_i | y_i) & ~(x_i & y_i)));
    // R3
    if (op_i == OP_SUB_YX) sub_yx_chk: assert (W'(res_o + x_i) == y_i);
    // R4
    if (op_i == OP_DEC) dec_chk: assert (W'(res_o + 1'b1) == x_i);
  end
endmodule

// File: tb/tb_alu4_top.sv
`timescale 1ns/1ps
module tb_alu4_top;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] x, y, res;
  logic [2:0] op;
  logic ovf, cy;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu4_top #(.W(W)) dut (
    .x_i(x), .y_i(y), .op_i(op),
    .res_o(res), .ovf_o(ovf), .carry_o(cy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s op=%0d x=%0d y=%0d actual=%0d expected=%0d", req, what, op, x, y, act, exp);
    end
  endtask

  initial begin
    x = '0; y = '0; op = 3'd0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 quiescent outputs
    chk("R9", "res", int'(res), 0);
    chk("R9", "ovf", int'(ovf), 0);
    chk("R9", "carry", int'(cy), 0);
    for (int o = 0; o < 8; o++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int sa, sb, full, sres, er, eo, ec;
          string rq;
          @(posedge clk);
          #2;
          op = 3'(o); x = 4'(a); y = 4'(b);
          sa = (a > 7) ? a - 16 : a;
          sb = (b > 7) ? b - 16 : b;
          full = 0; sres = 0; er = 0;
          case (o)
            0: begin full = a + b;            sres = sa + sb; rq = "R1"; end
            1: begin full = a + (15 - b) + 1; sres = sa - sb; rq = "R2"; end
            2: begin full = b + (15 - a) + 1; sres = sb - sa; rq = "R3"; end
            3: begin full = a + 1;            sres = sa + 1;  rq = "R4"; end
            4: begin full = a + 15;           sres = sa - 1;  rq = "R4"; end
            5: begin er = a & b; rq = "R5"; end
            6: begin er = a | b; rq = "R5"; end
            default: begin er = a ^ b; rq = "R5"; end
          endcase
          @(negedge clk);
          if (o < 5) begin
            er = full % 16;
            eo = (sres > 7 || sres < -8) ? 1 : 0;
            ec = full / 16;
            chk(rq, "res", int'(res), er);
            chk("R6", "ovf", int'(ovf), eo);
            chk("R8", "carry", int'(cy), ec);
          end else begin
            chk(rq, "res", int'(res), er);
            chk("R7", "ovf", int'(ovf), 0);
            chk("R7", "carry", int'(cy), 0);
          end
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule